// File: doc/BRIEF.md
# Two-Slot PCM Receive Deserializer

This block pulls two independent channel samples out of one serial PCM data line during every frame. A separate frame generator supplies three things: a frame-start pulse, a per-clock strobe for each rising and each falling edge of the bit clock, and the current bit position within the frame. The block runs on a system clock that is faster than the bit clock, and it passes the raw data line through a synchronizer. It delays the strobes, the frame start and the bit position by the same number of cycles as the synchronizer, so each bit is sampled at the value the line had when its strobe arrived.

Each channel has its own settings: a slot offset in bit clocks from frame start, a sample length, and a choice of sampling edge. Bits enter most significant first. When the last bit of a slot has arrived, the completed word is presented right-aligned on a wide output, together with its length and a one-cycle valid pulse. A consumer acknowledges each word. A word that completes while the previous one is still unacknowledged replaces it and raises an overrun indication. A length setting the slot logic cannot honour is flagged, and that channel then captures nothing.

Top module: `pcm_slot_rx`

## Requirements
- R1: A channel's first captured bit is the one whose sampling strobe arrives while `bit_pos` equals that channel's `cfg_offset` (0 to 255). `bit_pos` is 0 in the bit clock period that starts with `frame_start`.
- R2: A finished word holds exactly `cfg_length` bits in `word_data[c][cfg_length-1:0]`, and every bit above that position is zero. `word_len[c]` reports the length that was used.
- R3: Bits are assembled most significant first. The earliest captured bit lands at position `cfg_length-1` and the last captured bit lands at position 0.
- R4: `cfg_fall[c]` chooses the sampling strobe for each channel independently: 0 samples on `bclk_rise` and 1 samples on `bclk_fall`.
- R5: `cfg_err[c]` is 1 exactly when `cfg_length[c]` is 0, is above 640, or is above 24 and not a multiple of 8. While it is 1, that channel produces no word.
- R6: `word_valid[c]` is high for exactly one system clock per completed word. It is set by the second clock edge after the edge that samples the strobe of the channel's last bit.
- R7: `word_ovr[c]` pulses together with `word_valid[c]` when the previous word of that channel was not acknowledged through `word_ack[c]` before or during the completion edge. The new word replaces the old one.
- R8: `word_data` and `word_len` of a channel stay unchanged in every cycle in which its `word_valid` is low.
- R9: A new `frame_start` discards any partly captured slot. A slot that does not fit inside its frame never produces a word.
- R10: While reset is asserted, every valid, overrun, length and data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_rise | input | 1 | One-cycle strobe at each bit clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe at each bit clock falling edge |
| frame_start | input | 1 | Frame sync rising edge, coincident with a rising strobe |
| bit_pos | input | POS_W | Bit clock count since frame start |
| sdata_in | input | 1 | Asynchronous serial PCM data line |
| cfg_offset | input | 2 x OFF_W | Slot offset per channel |
| cfg_length | input | 2 x LEN_W | Sample length per channel |
| cfg_fall | input | 2 | Sampling edge per channel, 1 = falling |
| cfg_err | output | 2 | Illegal length per channel |
| word_ack | input | 2 | Consumer has taken the presented word |
| word_valid | output | 2 | One-cycle word completion pulse |
| word_ovr | output | 2 | Completion replaced an unacknowledged word |
| word_len | output | 2 x LEN_W | Length of the presented word |
| word_data | output | 2 x MAX_LEN | Right-aligned presented word |

## Verification
The assertions check four behaviours on every cycle. The valid pulse never lasts two cycles. An overrun never appears without a valid. The presented word and length stay still between completions. No bit is set above the reported length. They also confirm that a channel with an illegal length stays silent. Whether the bits are the correct ones, sampled on the chosen edge at the chosen offset and in MSB-first order, can only be shown by the bench's scenarios. The same holds for the exact latency of the valid pulse and for frames that end before a slot completes. The bench shows these by running one-hot and edge-split data patterns against a behavioural model.

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx #(
  parameter int MAX_LEN     = 640,
  parameter int OFF_W       = 8,
  parameter int POS_W       = 11,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bclk_rise,
  input  logic                          bclk_fall,
  input  logic                          frame_start,
  input  logic [POS_W-1:0]              bit_pos,
  input  logic                          sdata_in,
  input  logic [1:0][OFF_W-1:0]         cfg_offset,
  input  logic [1:0][LEN_W-1:0]         cfg_length,
  input  logic [1:0]                    cfg_fall,
  output logic [1:0]                    cfg_err,
  input  logic [1:0]                    word_ack,
  output logic [1:0]                    word_valid,
  output logic [1:0]                    word_ovr,
  output logic [1:0][LEN_W-1:0]         word_len,
  output logic [1:0][MAX_LEN-1:0]       word_data
);

  logic [SYNC_STAGES-1:0]            din_q, rise_q, fall_q, frm_q;
  logic [SYNC_STAGES-1:0][POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      frm_q  <= '0;
      pos_q  <= '0;
    end else begin
      din_q  <= {din_q[SYNC_STAGES-2:0], sdata_in};
      rise_q <= {rise_q[SYNC_STAGES-2:0], bclk_rise};
      fall_q <= {fall_q[SYNC_STAGES-2:0], bclk_fall};
      frm_q  <= {frm_q[SYNC_STAGES-2:0], frame_start};
      pos_q  <= {pos_q[SYNC_STAGES-2:0], bit_pos};
    end
  end

  wire             din_a  = din_q[SYNC_STAGES-1];
  wire             rise_a = rise_q[SYNC_STAGES-1];
  wire             fall_a = fall_q[SYNC_STAGES-1];
  wire             frm_a  = frm_q[SYNC_STAGES-1];
  wire [POS_W-1:0] pos_a  = pos_q[SYNC_STAGES-1];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [MAX_LEN-1:0] sh_q, out_q;
    logic [LEN_W-1:0]   cnt_q, len_q;
    logic               armed_q, pend_q, vld_q, ovr_q;

    wire [LEN_W-1:0] len = cfg_length[c];
    wire legal = (len != '0) && (len <= LEN_W'(MAX_LEN)) &&
                 ((len <= LEN_W'(24)) || (len[2:0] == 3'b000));
    wire strobe = cfg_fall[c] ? fall_a : rise_a;
    wire live   = frm_a | armed_q;
    wire take   = live & strobe & legal & (pos_a >= POS_W'(cfg_offset[c]));

    wire [LEN_W-1:0]   cnt_base = frm_a ? '0 : cnt_q;
    wire [MAX_LEN-1:0] sh_base  = frm_a ? '0 : sh_q;
    wire [LEN_W-1:0]   cnt_nx   = cnt_base + LEN_W'(1);
    wire [MAX_LEN-1:0] sh_nx    = {sh_base[MAX_LEN-2:0], din_a};
    wire               last     = take && (cnt_nx == len);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q    <= '0;
        out_q   <= '0;
        cnt_q   <= '0;
        len_q   <= '0;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
        vld_q   <= 1'b0;
        ovr_q   <= 1'b0;
      end else begin
        vld_q   <= last;
        ovr_q   <= last & pend_q & ~word_ack[c];
        armed_q <= live & ~last;
        if (last)             pend_q <= 1'b1;
        else if (word_ack[c]) pend_q <= 1'b0;
        if (frm_a | take) begin
          sh_q  <= take ? sh_nx  : '0;
          cnt_q <= take ? cnt_nx : '0;
        end
        if (last) begin
          out_q <= sh_nx;
          len_q <= len;
        end
      end
    end

    assign cfg_err[c]    = ~legal;
    assign word_valid[c] = vld_q;
    assign word_ovr[c]   = ovr_q;
    assign word_len[c]   = len_q;
    assign word_data[c]  = out_q;
  end

endmodule

// File: rtl/pcm_slot_rx_chk.sv
module pcm_slot_rx_chk #(
  parameter int MAX_LEN = 640,
  parameter int LEN_W   = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              cfg_err,
  input logic [1:0]              word_valid,
  input logic [1:0]              word_ovr,
  input logic [1:0][LEN_W-1:0]   word_len,
  input logic [1:0][MAX_LEN-1:0] word_data
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid[c] |=> !word_valid[c]);

    p_ovr_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_ovr[c] |-> word_valid[c]);

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid[c] |-> ($stable(word_data[c]) && $stable(word_len[c])));

    p_right_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid[c] |-> (((word_data[c] >> word_len[c]) == '0) && (word_len[c] != '0)));

    p_illegal_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_err[c]) && cfg_err[c]) |-> !word_valid[c]);
  end

endmodule

bind pcm_slot_rx pcm_slot_rx_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_err    (cfg_err),
  .word_valid (word_valid),
  .word_ovr   (word_ovr),
  .word_len   (word_len),
  .word_data  (word_data)
);

// File: tb/tb_pcm_slot_rx.sv
module tb_pcm_slot_rx;
  localparam int CLK_PERIOD = 10;
  localparam int ML = 640;
  localparam int LW = 10;
  localparam int PW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_rise = 0, bclk_fall = 0, frame_start = 0, sdata_in = 0;
  logic [PW-1:0] bit_pos = '0;
  logic [1:0][7:0] cfg_offset = '0;
  logic [1:0][LW-1:0] cfg_length = '0;
  logic [1:0] cfg_fall = '0, word_ack = '0;
  logic [1:0] cfg_err, word_valid, word_ovr;
  logic [1:0][LW-1:0] word_len;
  logic [1:0][ML-1:0] word_data;

  pcm_slot_rx dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int nval[2], nov[2];
  logic [ML-1:0] last_word[2];
  logic [1:0] auto_ack = 2'b11;
  int data_mode = 0, mark = 0;

  // reference model state
  logic d1_r, d1_f, d1_s, d1_d, d2_r, d2_f, d2_s, d2_d;
  logic [PW-1:0] d1_p, d2_p;
  logic m_armed[2], m_pend[2], m_valid[2], m_ovr[2];
  int m_cnt[2];
  logic [ML-1:0] m_acc[2], m_data[2];
  logic [LW-1:0] m_len[2];

  function automatic bit legal_len(int l);
    return (l >= 1) && (l <= 640) && ((l <= 24) || (l % 8 == 0));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {d1_r, d1_f, d1_s, d1_d, d2_r, d2_f, d2_s, d2_d} = '0;
      d1_p = '0; d2_p = '0;
      for (int c = 0; c < 2; c++) begin
        m_armed[c] = 0; m_pend[c] = 0; m_valid[c] = 0; m_ovr[c] = 0;
        m_cnt[c] = 0; m_acc[c] = '0; m_data[c] = '0; m_len[c] = '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        automatic bit e    = cfg_fall[c] ? d2_f : d2_r;
        automatic bit live = d2_s || m_armed[c];
        automatic bit take = live && e && legal_len(int'(cfg_length[c])) &&
                             (int'(d2_p) >= int'(cfg_offset[c]));
        automatic bit fin;
        if (d2_s) begin m_cnt[c] = 0; m_acc[c] = '0; end
        if (take) begin m_acc[c] = {m_acc[c][ML-2:0], d2_d}; m_cnt[c]++; end
        fin = take && (m_cnt[c] == int'(cfg_length[c]));
        m_valid[c] = fin;
        m_ovr[c] = fin && m_pend[c] && !word_ack[c];
        if (fin) begin m_pend[c] = 1; m_data[c] = m_acc[c]; m_len[c] = cfg_length[c]; end
        else if (word_ack[c]) m_pend[c] = 0;
        m_armed[c] = live && !fin;
      end
      d2_r = d1_r; d2_f = d1_f; d2_s = d1_s; d2_d = d1_d; d2_p = d1_p;
      d1_r = bclk_rise; d1_f = bclk_fall; d1_s = frame_start; d1_d = sdata_in; d1_p = bit_pos;
    end
  end

  task automatic chk(bit ok, string req, logic [ML-1:0] act, logic [ML-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        chk(word_valid[c] == m_valid[c], "R6 valid vs model", ML'(word_valid[c]), ML'(m_valid[c]));
        chk(word_ovr[c] == m_ovr[c], "R7 overrun vs model", ML'(word_ovr[c]), ML'(m_ovr[c]));
        chk(word_data[c] == m_data[c], "R3 data vs model", word_data[c], m_data[c]);
        chk(word_len[c] == m_len[c], "R2 length vs model", ML'(word_len[c]), ML'(m_len[c]));
        chk(cfg_err[c] == !legal_len(int'(cfg_length[c])), "R5 cfg_err",
            ML'(cfg_err[c]), ML'(!legal_len(int'(cfg_length[c]))));
        if (word_valid[c]) begin nval[c]++; last_word[c] = word_data[c]; end
        if (word_ovr[c]) nov[c]++;
      end
    end
    for (int c = 0; c < 2; c++) word_ack[c] = auto_ack[c] && word_valid[c];
  endtask

  function automatic logic val(int p);
    if (data_mode == 0) return logic'($urandom & 1);
    return p == mark;
  endfunction

  task automatic frames(int n, int fbits);
    sdata_in = (data_mode == 2) ? ~val(0) : val(0);
    for (int f = 0; f < n; f++)
      for (int b = 0; b < fbits; b++)
        for (int ph = 0; ph < 8; ph++) begin
          step();
          bclk_rise = (ph == 0);
          bclk_fall = (ph == 4);
          frame_start = (ph == 0) && (b == 0);
          bit_pos = PW'(b);
          if (ph == 2) sdata_in = val(b);
          if (ph == 6) sdata_in = (data_mode == 2) ? ~val((b + 1) % fbits) : val((b + 1) % fbits);
        end
    for (int i = 0; i < 8; i++) begin
      step();
      bclk_rise = 0; bclk_fall = 0; frame_start = 0;
    end
  endtask

  task automatic setup(int o0, int l0, bit f0, int o1, int l1, bit f1);
    cfg_offset[0] = 8'(o0); cfg_length[0] = LW'(l0); cfg_fall[0] = f0;
    cfg_offset[1] = 8'(o1); cfg_length[1] = LW'(l1); cfg_fall[1] = f1;
    for (int c = 0; c < 2; c++) begin nval[c] = 0; nov[c] = 0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    setup(0, 8, 0, 9, 16, 1);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(word_valid == 0 && word_ovr == 0, "R10 reset flags", ML'({word_valid, word_ovr}), '0);
    chk(word_data[0] == 0 && word_data[1] == 0, "R10 reset data", word_data[0] | word_data[1], '0);
    chk(word_len == 0, "R10 reset length", ML'(word_len), '0);
    rst_n = 1;

    // random data, mixed edges
    data_mode = 0;
    frames(4, 32);
    chk(nval[0] == 4, "R6 one word per frame ch0", ML'(nval[0]), ML'(4));
    chk(nval[1] == 4, "R6 one word per frame ch1", ML'(nval[1]), ML'(4));

    // R1 R3 one-hot marker
    data_mode = 1; mark = 3;
    setup(3, 8, 0, 5, 4, 1);
    frames(2, 32);
    chk(last_word[0] == ML'(8'h80), "R1 R3 first bit at offset is MSB", last_word[0], ML'(8'h80));
    chk(last_word[1] == '0, "R1 offset excludes earlier bit", last_word[1], '0);
    mark = 10;
    frames(2, 32);
    chk(last_word[0] == ML'(1), "R3 last bit lands at bit 0", last_word[0], ML'(1));

    // R4 edge split: rising sees inverted data
    data_mode = 2; mark = 3;
    setup(3, 8, 0, 3, 8, 1);
    frames(2, 32);
    chk(last_word[0] == ML'(8'h7F), "R4 rising edge sample", last_word[0], ML'(8'h7F));
    chk(last_word[1] == ML'(8'h80), "R4 falling edge sample", last_word[1], ML'(8'h80));

    // R2 maximum length and offset
    data_mode = 0;
    setup(255, 640, 0, 0, 24, 1);
    frames(2, 900);
    chk(nval[0] == 2, "R2 640-bit words", ML'(nval[0]), ML'(2));
    chk(nval[1] == 2, "R2 24-bit words", ML'(nval[1]), ML'(2));

    // R5 illegal lengths
    setup(0, 25, 0, 0, 0, 1);
    step();
    chk(cfg_err == 2'b11, "R5 lengths 25 and 0 flagged", ML'(cfg_err), ML'(2'b11));
    frames(2, 64);
    chk(nval[0] + nval[1] == 0, "R5 illegal channels silent", ML'(nval[0] + nval[1]), '0);
    setup(0, 641, 0, 0, 40, 1);
    step();
    chk(cfg_err == 2'b01, "R5 641 illegal, 40 legal", ML'(cfg_err), ML'(2'b01));
    frames(2, 64);
    chk(nval[0] == 0 && nval[1] == 2, "R5 only legal channel delivers",
        ML'({nval[0][7:0], nval[1][7:0]}), ML'(16'h0002));

    // R7 overrun without acknowledge
    auto_ack = 2'b00;
    setup(0, 8, 0, 16, 8, 1);
    frames(3, 32);
    chk(nov[0] == 2, "R7 overrun ch0", ML'(nov[0]), ML'(2));
    chk(nov[1] == 2, "R7 overrun ch1", ML'(nov[1]), ML'(2));
    auto_ack = 2'b11;
    frames(1, 32);
    setup(0, 8, 0, 16, 8, 1);
    frames(2, 32);
    chk(nov[0] + nov[1] == 0, "R7 no overrun when acknowledged", ML'(nov[0] + nov[1]), '0);

    // R9 slot longer than frame
    setup(10, 10, 0, 0, 4, 1);
    frames(3, 16);
    chk(nval[0] == 0, "R9 truncated slot discarded", ML'(nval[0]), '0);
    chk(nval[1] == 3, "R9 short slot still delivered", ML'(nval[1]), ML'(3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule